// File: doc/BRIEF.md
# Embedded Logic Analyzer Capture Core

This block is an on-chip logic analyzer that runs on the clock of the logic it watches. Every cycle in which `probe_valid` is high, it compares the probe bus against a bank of programmable match units. It then steps a trigger sequencer through a chain of levels. When the last level fires, the trigger is declared. Independently of the sequencer, a Boolean storage-qualification condition, built from the same match results, decides sample by sample whether the current probe word is written to the circular sample memory.

Capture is therefore not a plain trigger-then-fill. Before the trigger, qualified samples circulate in the memory, and the most recent of them (up to a programmed pre-trigger count) are kept. After the trigger, qualified samples fill the rest of the memory, and then capture stops. Software-side logic loads the match values, care masks, invert flags, the source unit of each level, the last level index, the qualification set and mode, and the pre-trigger count through a register-style write port. It pulses `arm`, waits for `st_done`, and reads the window back in chronological order by logical index.

The probe input is a valid-only stream. The analyzer never applies back-pressure: there is no ready signal, every valid word is consumed in its cycle, and a cycle with `probe_valid` low is simply not a sample.

Top module: `la_capture_core`

## Requirements
- R1: After reset, `st_armed`, `st_triggered` and `st_done` are all 0.
- R2: Match unit j hits when `((probe_data ^ value_j) & mask_j) == 0`, XORed with its invert flag. A mask bit of 0 makes that channel don't-care, so a zero mask with invert clear hits on every sample.
- R3: The sequencer starts at level 0. On each armed, untriggered valid sample, it advances one level when the unit selected by the current level hits. When the last programmed level hits, the trigger fires, and `st_triggered` is 1 from the following clock edge on.
- R4: A pulse on `arm` returns the sequencer to level 0, clears the triggered and done flags, empties the memory pointers, and sets `st_armed` from the next edge.
- R5: Qualification: with an empty qualification set, every valid sample is stored. Otherwise, in any-mode a sample is stored when at least one unit in the set hits, and in all-mode when every unit in the set hits.
- R6: The number of pre-trigger samples kept is the smaller of the qualified samples seen before the trigger sample and the programmed pre-trigger count. `trig_index` reports this number after the trigger. It is the logical index of the first sample at or after the trigger.
- R7: The trigger sample itself, if qualified, is the first post-trigger sample. Capture ends when pre-trigger kept plus post-trigger stored equals the depth. `st_done` rises and `st_armed` falls on the edge that stores the last sample.
- R8: Once done, `rd_data` returns the sample at logical index `rd_addr` (0 = oldest) one cycle after `rd_addr` is applied.
- R9: A cycle with `probe_valid` low is ignored: it neither stores a sample nor advances the sequencer, whatever is on `probe_data`.
- R10: After done and before the next `arm`, probe activity has no effect: the read-back window and the status flags stay unchanged.
- R11: Configuration writes use `cfg_addr[6:4]` as field kind and `cfg_addr[3:0]` as unit or level index. The kinds are: 0 match value, 1 match care mask, 2 match invert (bit 0), 3 level source unit, 4 last level index (levels in use minus one), 5 qualification unit set (bit per unit), 6 qualification mode (bit 0: 1 = all, 0 = any), 7 pre-trigger count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Design clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Field kind [6:4] and index [3:0] |
| cfg_wdata | input | CFG_W | Configuration write data |
| arm | input | 1 | Single-cycle pulse starting a new capture |
| probe_valid | input | 1 | Probe word present this cycle |
| probe_data | input | PROBE_W | Probe bus |
| rd_addr | input | DEPTH_LOG2 | Logical read index, 0 = oldest |
| rd_data | output | PROBE_W | Sample at the logical index, one cycle later |
| st_armed | output | 1 | Capture in progress |
| st_triggered | output | 1 | Trigger has fired |
| st_done | output | 1 | Window complete, memory readable |
| trig_index | output | DEPTH_LOG2 | Logical index of the first post-trigger sample |

## Verification
The bench builds the core with an 8-bit probe, four match units, four levels and a 16-entry memory. The small depth lets each capture wrap the circular buffer many times before the trigger, and lets the full window, including the case where the pre-trigger count leaves a single post-trigger slot, be read back entry by entry. The bench sweeps pre-trigger count, number of levels, qualification mode, invert flag and a gapped-valid stream. A reference model predicts the exact trigger edge and the expected sixteen samples of every run.

// File: rtl/la_pkg.sv
package la_pkg;
  localparam int CFG_KIND_W = 3;
  localparam int CFG_IDX_W  = 4;
  localparam int CFG_ADDR_W = CFG_KIND_W + CFG_IDX_W;

  typedef enum logic [CFG_KIND_W-1:0] {
    CK_VALUE = 3'd0,
    CK_MASK  = 3'd1,
    CK_NEG   = 3'd2,
    CK_LSEL  = 3'd3,
    CK_LLAST = 3'd4,
    CK_QSEL  = 3'd5,
    CK_QMODE = 3'd6,
    CK_PRE   = 3'd7
  } cfg_kind_e;
endpackage

// File: rtl/la_match_unit.sv
module la_match_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] probe,
  input  logic [W-1:0] value,
  input  logic [W-1:0] care,
  input  logic         invert,
  output logic         hit
);
  logic [W-1:0] diff;

  always_comb begin
    diff = (probe ^ value) & care;
    hit  = (diff == '0) ^ invert;
  end
endmodule

// File: rtl/la_sequencer.sv
module la_sequencer #(
  parameter int N_MATCH = 4,
  parameter int N_LEVEL = 4,
  parameter int MSEL_W  = 2,
  parameter int LVL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              step,
  input  logic [N_MATCH-1:0] hits,
  input  logic [MSEL_W-1:0] lvl_src [N_LEVEL],
  input  logic [LVL_W-1:0]  last_lvl,
  output logic              fire,
  output logic [LVL_W-1:0]  level
);
  logic [MSEL_W-1:0] cur_src;
  logic              cur_hit;

  always_comb begin
    cur_src = lvl_src[level];
    cur_hit = (int'(cur_src) < N_MATCH) ? hits[cur_src] : 1'b0;
    fire    = step & cur_hit & (level == last_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                level <= '0;
    else if (arm || fire)      level <= '0;
    else if (step && cur_hit)  level <= level + 1'b1;
  end

  // R3
  lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> (level == '0 || level == $past(level) + 1'b1));

  // R9
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !arm) |=> $stable(level));
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl #(
  parameter int DL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          valid,
  input  logic          qual,
  input  logic          fire,
  input  logic [DL-1:0] pretrig,
  output logic          armed,
  output logic          triggered,
  output logic          done,
  output logic          step,
  output logic          wr_en,
  output logic [DL-1:0] wr_addr,
  output logic [DL-1:0] kept
);
  localparam int DEPTH = 1 << DL;

  logic [DL-1:0] pre_cnt, kept_eff;
  logic [DL:0]   post_cnt, post_goal;
  logic          in_post, fill_done;

  always_comb begin
    step      = armed & valid & ~triggered;
    wr_en     = armed & valid & qual;
    in_post   = triggered | fire;
    kept_eff  = triggered ? kept : pre_cnt;
    post_goal = (DL+1)'(DEPTH) - {1'b0, kept_eff};
    fill_done = wr_en & in_post & ((post_cnt + 1'b1) == post_goal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; triggered <= 1'b0; done <= 1'b0;
      wr_addr <= '0; pre_cnt <= '0; post_cnt <= '0; kept <= '0;
    end else if (arm) begin
      armed <= 1'b1; triggered <= 1'b0; done <= 1'b0;
      wr_addr <= '0; pre_cnt <= '0; post_cnt <= '0; kept <= '0;
    end else begin
      if (wr_en) wr_addr <= wr_addr + 1'b1;
      if (wr_en && !in_post && pre_cnt < pretrig) pre_cnt <= pre_cnt + 1'b1;
      if (fire) begin
        triggered <= 1'b1;
        kept      <= pre_cnt;
      end
      if (wr_en && in_post) post_cnt <= post_cnt + 1'b1;
      if (fill_done) begin
        armed <= 1'b0;
        done  <= 1'b1;
      end
    end
  end

  // R7
  done_has_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (triggered && !armed));

  // R10
  frozen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> ($stable(wr_addr) && done));

  // R4
  arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (armed && !triggered && !done));

  // R3
  trig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !arm) |=> triggered);
endmodule

// File: rtl/la_sample_mem.sv
module la_sample_mem #(
  parameter int W  = 8,
  parameter int DL = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [DL-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [DL-1:0] rd_base,
  input  logic [DL-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int DEPTH = 1 << DL;

  logic [W-1:0]  mem [DEPTH];
  logic [DL-1:0] phys;

  always_comb phys = rd_base + rd_addr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[phys];
  end
endmodule

// File: rtl/la_capture_core.sv
module la_capture_core
  import la_pkg::*;
#(
  parameter int PROBE_W    = 8,
  parameter int N_MATCH    = 4,
  parameter int N_LEVEL    = 4,
  parameter int DEPTH_LOG2 = 8,
  parameter int CFG_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic                  arm,
  input  logic                  probe_valid,
  input  logic [PROBE_W-1:0]    probe_data,
  input  logic [DEPTH_LOG2-1:0] rd_addr,
  output logic [PROBE_W-1:0]    rd_data,
  output logic                  st_armed,
  output logic                  st_triggered,
  output logic                  st_done,
  output logic [DEPTH_LOG2-1:0] trig_index
);
  localparam int MSEL_W = (N_MATCH > 1) ? $clog2(N_MATCH) : 1;
  localparam int LVL_W  = (N_LEVEL > 1) ? $clog2(N_LEVEL) : 1;

  logic [PROBE_W-1:0]    m_value [N_MATCH];
  logic [PROBE_W-1:0]    m_care  [N_MATCH];
  logic [N_MATCH-1:0]    m_inv;
  logic [MSEL_W-1:0]     lvl_src [N_LEVEL];
  logic [LVL_W-1:0]      last_lvl;
  logic [N_MATCH-1:0]    q_set;
  logic                  q_all;
  logic [DEPTH_LOG2-1:0] pretrig;

  cfg_kind_e             kind;
  logic [CFG_IDX_W-1:0]  idx;

  always_comb begin
    kind = cfg_kind_e'(cfg_addr[CFG_ADDR_W-1:CFG_IDX_W]);
    idx  = cfg_addr[CFG_IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_MATCH; i++) begin
        m_value[i] <= '0;
        m_care[i]  <= '0;
      end
      for (int l = 0; l < N_LEVEL; l++) lvl_src[l] <= '0;
      m_inv    <= '0;
      last_lvl <= '0;
      q_set    <= '0;
      q_all    <= 1'b0;
      pretrig  <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < N_MATCH; i++) begin
        if (int'(idx) == i) begin
          if (kind == CK_VALUE) m_value[i] <= cfg_wdata[PROBE_W-1:0];
          if (kind == CK_MASK)  m_care[i]  <= cfg_wdata[PROBE_W-1:0];
          if (kind == CK_NEG)   m_inv[i]   <= cfg_wdata[0];
        end
      end
      for (int l = 0; l < N_LEVEL; l++) begin
        if (int'(idx) == l && kind == CK_LSEL) lvl_src[l] <= cfg_wdata[MSEL_W-1:0];
      end
      if (kind == CK_LLAST) last_lvl <= cfg_wdata[LVL_W-1:0];
      if (kind == CK_QSEL)  q_set    <= cfg_wdata[N_MATCH-1:0];
      if (kind == CK_QMODE) q_all    <= cfg_wdata[0];
      if (kind == CK_PRE)   pretrig  <= cfg_wdata[DEPTH_LOG2-1:0];
    end
  end

  logic [N_MATCH-1:0] hits;

  for (genvar g = 0; g < N_MATCH; g++) begin : g_match
    la_match_unit #(.W(PROBE_W)) u_match (
      .probe  (probe_data),
      .value  (m_value[g]),
      .care   (m_care[g]),
      .invert (m_inv[g]),
      .hit    (hits[g])
    );
  end

  logic qual;
  always_comb begin
    if (q_set == '0)  qual = 1'b1;
    else if (q_all)   qual = &(hits | ~q_set);
    else              qual = |(hits & q_set);
  end

  logic                  fire, step, wr_en;
  logic [LVL_W-1:0]      level;
  logic [DEPTH_LOG2-1:0] wr_addr;

  la_sequencer #(
    .N_MATCH (N_MATCH),
    .N_LEVEL (N_LEVEL),
    .MSEL_W  (MSEL_W),
    .LVL_W   (LVL_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .step     (step),
    .hits     (hits),
    .lvl_src  (lvl_src),
    .last_lvl (last_lvl),
    .fire     (fire),
    .level    (level)
  );

  la_capture_ctrl #(.DL(DEPTH_LOG2)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .valid     (probe_valid),
    .qual      (qual),
    .fire      (fire),
    .pretrig   (pretrig),
    .armed     (st_armed),
    .triggered (st_triggered),
    .done      (st_done),
    .step      (step),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .kept      (trig_index)
  );

  la_sample_mem #(.W(PROBE_W), .DL(DEPTH_LOG2)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (probe_data),
    .rd_base (wr_addr),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R5
  store_only_when_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (st_armed && probe_valid));
endmodule

// File: tb/la_capture_core_tb_top.sv
`timescale 1ns/1ps
module la_capture_core_tb_top;
  localparam int PW = 8;
  localparam int DL = 4;
  localparam int DEPTH = 1 << DL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [6:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          arm = 1'b0;
  logic          probe_valid = 1'b0;
  logic [PW-1:0] probe_data = '0;
  logic [DL-1:0] rd_addr = '0;
  logic [PW-1:0] rd_data;
  logic          st_armed, st_triggered, st_done;
  logic [DL-1:0] trig_index;

  int n_tests = 0;
  int n_fail  = 0;

  la_capture_core #(
    .PROBE_W(PW), .N_MATCH(4), .N_LEVEL(4), .DEPTH_LOG2(DL), .CFG_W(16)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .arm(arm), .probe_valid(probe_valid),
    .probe_data(probe_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .st_armed(st_armed), .st_triggered(st_triggered), .st_done(st_done),
    .trig_index(trig_index)
  );

  always #5 clk = ~clk;

  // model state
  int          mlvl, npre, npost, kept, target;
  bit          mtrig, mdone;
  logic [7:0]  prebuf [4096];
  logic [7:0]  postbuf [DEPTH];
  logic [7:0]  expbuf [DEPTH];

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int kind, input int idx, input int data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = {kind[2:0], idx[3:0]};
    cfg_wdata = data[15:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R2: match definition used by the model
  function automatic bit hitf(input int j, input logic [7:0] v, input bit ng);
    case (j)
      0: return (v == 8'h10) ^ ng;
      1: return (v == 8'h20);
      2: return 1'b1;
      default: return (v[0] == 1'b0) ^ ng;
    endcase
  endfunction

  // R5: qualification definition used by the model
  function automatic bit qualf(input int qm, input logic [7:0] v, input bit ng);
    if (qm == 0) return 1'b1;
    if (qm == 1) return hitf(3, v, ng);
    return hitf(3, v, ng) && hitf(2, v, ng);
  endfunction

  task automatic post_store(input logic [7:0] v);
    postbuf[npost] = v;
    npost++;
    if (npost == target) mdone = 1'b1;
  endtask

  task automatic model_step(input logic [7:0] v, input int nl, input int qm,
                            input int pt, input bit ng);
    bit q;
    q = qualf(qm, v, ng);
    if (!mtrig) begin
      if (hitf(mlvl, v, ng) && mlvl == nl - 1) begin
        mtrig  = 1'b1;
        kept   = (npre < pt) ? npre : pt;
        target = DEPTH - kept;
        if (q) post_store(v);
      end else begin
        if (q && npre < 4096) begin prebuf[npre] = v; npre++; end
        if (hitf(mlvl, v, ng)) mlvl++;
      end
    end else if (!mdone && q) begin
      post_store(v);
    end
  endtask

  task automatic run_case(input int pt, input int nl, input int qm,
                          input int pat, input bit ng);
    bit finished;
    // R11 field map
    cfg_write(0, 0, 8'h10); cfg_write(1, 0, 8'hFF); cfg_write(2, 0, ng);
    cfg_write(0, 1, 8'h20); cfg_write(1, 1, 8'hFF); cfg_write(2, 1, 0);
    cfg_write(0, 2, 8'h00); cfg_write(1, 2, 8'h00); cfg_write(2, 2, 0);
    cfg_write(0, 3, 8'h00); cfg_write(1, 3, 8'h01); cfg_write(2, 3, ng);
    for (int l = 0; l < 4; l++) cfg_write(3, l, l);
    cfg_write(4, 0, nl - 1);
    cfg_write(5, 0, (qm == 0) ? 0 : ((qm == 1) ? 4'b1000 : 4'b1100));
    cfg_write(6, 0, (qm == 2) ? 1 : 0);
    cfg_write(7, 0, pt);

    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    chk("R4 armed after arm", st_armed, 1);
    chk("R4 triggered cleared", st_triggered, 0);
    chk("R4 done cleared", st_done, 0);

    mlvl = 0; npre = 0; npost = 0; kept = 0; target = DEPTH;
    mtrig = 1'b0; mdone = 1'b0; finished = 1'b0;

    for (int k = 0; k < 4000; k++) begin
      logic [7:0] v;
      bit vld;
      if (k > 0) begin
        @(negedge clk);
        chk("R3 trigger edge", st_triggered, mtrig);
        chk("R7 done edge", st_done, mdone);
        if (mdone) begin finished = 1'b1; break; end
      end
      if (pat == 0) begin
        vld = 1'b1;
        v = k[7:0];
      end else begin
        vld = (k % 3) != 0;          // R9 gapped stream
        v = vld ? 8'((k * 37) + 5) : ((k & 1) ? 8'h20 : 8'h10);
      end
      probe_valid = vld;
      probe_data  = v;
      if (vld) model_step(v, nl, qm, pt, ng);
    end
    if (!finished) chk("R7 capture completes", 0, 1);

    // R10: activity after done has no effect
    for (int j = 0; j < 12; j++) begin
      probe_valid = 1'b1;
      probe_data  = 8'(j * 11);
      @(negedge clk);
    end
    probe_valid = 1'b0;
    chk("R10 done stays", st_done, 1);
    chk("R7 armed low after done", st_armed, 0);
    chk("R6 trigger index", trig_index, kept);

    for (int i = 0; i < DEPTH; i++)
      expbuf[i] = (i < kept) ? prebuf[npre - kept + i] : postbuf[i - kept];
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = i[DL-1:0];
      @(negedge clk);
      chk("R8 R5 R10 readback", rd_data, expbuf[i]);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int pts[3] = '{0, 5, 15};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset armed", st_armed, 0);
    chk("R1 reset triggered", st_triggered, 0);
    chk("R1 reset done", st_done, 0);

    for (int p = 0; p < 3; p++)
      for (int nl = 1; nl <= 4; nl++)
        for (int qm = 0; qm < 3; qm++)
          for (int pat = 0; pat < 2; pat++)
            for (int ng = 0; ng < 2; ng++)
              run_case(pts[p], nl, qm, pat, ng[0]);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule